// File: doc/BRIEF.md
# Serial Synthesizer Programming Port

This block is the programming front end of a frequency synthesizer. A host drives three slow wires: a serial clock, a data line and a load strobe. Each rising serial clock edge shifts one data bit into a 24-bit word, most significant bit first. A rising edge on the load strobe copies the assembled word into one of four internal registers. The two least significant bits of the word pick the register. The registers drive the synthesizer's control fields: the reference divide value, the A and B counter values of the feedback divider, the antibacklash width, the lock-detect precision, the test bits and the function word.

All three wires are asynchronous to the system clock. They pass through a synchronizer, and their edges are detected in the system clock domain. The serial clock and the strobe must therefore each stay at a level for several system clock cycles.

Writing the initialization register loads the function fields with the same mapping as a function write. It also raises a strobe for one cycle. A reference write whose divide value is zero is stored, and a flag marks it as invalid.

Top module: `synth_prog_port`

## Requirements
- R1: After reset every output is zero, including `ref_bad_o` and `init_pulse_o`.
- R2: Each rising serial clock edge shifts one bit in, MSB first. Only the last 24 bits shifted before a load strobe count; earlier bits drop out.
- R3: A load with word bits [1:0] = 00 updates the reference fields: `ref_div_o` = bits [15:2], `abw_o` = bits [17:16], `test_bits_o` = bits [19:18], `lock_prec_o` = bit [20].
- R4: A load with bits [1:0] = 01 sets `a_cnt_o` = bits [7:2] and `b_cnt_o` = bits [20:8].
- R5: A load with bits [1:0] = 10 sets `func_word_o` = bits [23:2] and produces no init strobe.
- R6: A load with bits [1:0] = 11 sets `func_word_o` = bits [23:2] and raises `init_pulse_o` for exactly one system clock cycle.
- R7: A load changes only the fields of the addressed register; all other outputs keep their values.
- R8: A reference load with a divide value of 0 stores the 0 and sets `ref_bad_o`. Any reference load with a nonzero value clears it.
- R9: Shifting bits without a load strobe leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdata_i | input | 1 | Serial data (asynchronous) |
| sle_i | input | 1 | Load strobe (asynchronous) |
| ref_div_o | output | 14 | Reference divide value |
| ref_bad_o | output | 1 | Last reference write held a divide value of zero |
| abw_o | output | 2 | Antibacklash width select |
| test_bits_o | output | 2 | Test bits (00 in normal use) |
| lock_prec_o | output | 1 | Lock-detect precision select |
| a_cnt_o | output | 6 | A counter value |
| b_cnt_o | output | 13 | B counter value |
| func_word_o | output | 22 | Function/initialization word bits [23:2] |
| init_pulse_o | output | 1 | One-cycle strobe on an initialization write |

## Verification
A wire edge reaches the internal edge detect two system clocks after the first sampling edge. The register update lands on the clock after that, so results appear three cycles after a strobe rises. The bench holds every serial level for at least four clocks. After each word it waits ten more clocks before comparing outputs, well past that latency. The init strobe is counted on falling clock edges across the whole load window, so its one-cycle width is checked without sampling in a fixed cycle.

// File: rtl/spp_pkg.sv
package spp_pkg;

    localparam int WORD_W  = 24;
    localparam int ADDR_W  = 2;
    localparam int REF_W   = 14;
    localparam int A_W     = 6;
    localparam int B_W     = 13;
    localparam int FUNC_W  = WORD_W - ADDR_W;

    localparam int REF_LSB  = 2;
    localparam int ABW_LSB  = 16;
    localparam int TEST_LSB = 18;
    localparam int PREC_BIT = 20;
    localparam int A_LSB    = 2;
    localparam int B_LSB    = 8;

    typedef enum logic [ADDR_W-1:0] {
        SEL_REF  = 2'b00,
        SEL_NDIV = 2'b01,
        SEL_FUNC = 2'b10,
        SEL_INIT = 2'b11
    } sel_e;

    typedef struct packed {
        logic [REF_W-1:0]  ref_div;
        logic              ref_bad;
        logic [1:0]        abw;
        logic [1:0]        test_bits;
        logic              lock_prec;
        logic [A_W-1:0]    a_cnt;
        logic [B_W-1:0]    b_cnt;
        logic [FUNC_W-1:0] func_word;
        logic              init_pulse;
    } bank_t;

endpackage

// File: rtl/spp_sync.sv
module spp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_t;

    sync_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.pipe[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            state_d.pipe[i] = state_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sync_o = state_q.pipe[STAGES-1];

endmodule

// File: rtl/spp_edge_det.sv
module spp_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    typedef struct packed {
        logic last;
    } edge_t;

    edge_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.last = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rise_o = level_i & ~state_q.last;

endmodule

// File: rtl/spp_shifter.sv
module spp_shifter #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] word_o
);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } shift_t;

    shift_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (shift_i) begin
            state_d.word = {state_q.word[WIDTH-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign word_o = state_q.word;

endmodule

// File: rtl/spp_latch_bank.sv
module spp_latch_bank
    import spp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output bank_t             bank_o
);

    bank_t state_d, state_q;
    sel_e  sel;

    assign sel = sel_e'(word_i[ADDR_W-1:0]);

    always_comb begin
        state_d            = state_q;
        state_d.init_pulse = 1'b0;
        if (load_i) begin
            unique case (sel)
                SEL_REF: begin
                    state_d.ref_div   = word_i[REF_LSB +: REF_W];
                    state_d.ref_bad   = (word_i[REF_LSB +: REF_W] == '0);
                    state_d.abw       = word_i[ABW_LSB +: 2];
                    state_d.test_bits = word_i[TEST_LSB +: 2];
                    state_d.lock_prec = word_i[PREC_BIT];
                end
                SEL_NDIV: begin
                    state_d.a_cnt = word_i[A_LSB +: A_W];
                    state_d.b_cnt = word_i[B_LSB +: B_W];
                end
                SEL_FUNC: begin
                    state_d.func_word = word_i[WORD_W-1:ADDR_W];
                end
                SEL_INIT: begin
                    state_d.func_word  = word_i[WORD_W-1:ADDR_W];
                    state_d.init_pulse = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bank_o = state_q;

endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
    import spp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdata_i,
    input  logic              sle_i,
    output logic [REF_W-1:0]  ref_div_o,
    output logic              ref_bad_o,
    output logic [1:0]        abw_o,
    output logic [1:0]        test_bits_o,
    output logic              lock_prec_o,
    output logic [A_W-1:0]    a_cnt_o,
    output logic [B_W-1:0]    b_cnt_o,
    output logic [FUNC_W-1:0] func_word_o,
    output logic              init_pulse_o
);

    localparam int NWIRES = 3;

    logic [NWIRES-1:0] wires_s;
    logic              sclk_rise;
    logic              le_rise;
    logic [WORD_W-1:0] shift_word;
    bank_t             bank;

    spp_sync #(.WIDTH(NWIRES), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({sle_i, sclk_i, sdata_i}),
        .sync_o (wires_s)
    );

    spp_edge_det i_sclk_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(wires_s[1]),
        .rise_o (sclk_rise)
    );

    spp_edge_det i_le_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(wires_s[2]),
        .rise_o (le_rise)
    );

    spp_shifter #(.WIDTH(WORD_W)) i_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift_i(sclk_rise),
        .bit_i  (wires_s[0]),
        .word_o (shift_word)
    );

    spp_latch_bank i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(le_rise),
        .word_i(shift_word),
        .bank_o(bank)
    );

    assign ref_div_o    = bank.ref_div;
    assign ref_bad_o    = bank.ref_bad;
    assign abw_o        = bank.abw;
    assign test_bits_o  = bank.test_bits;
    assign lock_prec_o  = bank.lock_prec;
    assign a_cnt_o      = bank.a_cnt;
    assign b_cnt_o      = bank.b_cnt;
    assign func_word_o  = bank.func_word;
    assign init_pulse_o = bank.init_pulse;

endmodule

// File: rtl/spp_checker.sv
module spp_checker
    import spp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              le_rise,
    input logic [REF_W-1:0]  ref_div_o,
    input logic              ref_bad_o,
    input logic [A_W-1:0]    a_cnt_o,
    input logic [B_W-1:0]    b_cnt_o,
    input logic [FUNC_W-1:0] func_word_o,
    input logic              init_pulse_o
);

    assert_init_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse_o |=> !init_pulse_o);

    assert_init_from_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_pulse_o) |-> $past(le_rise));

    assert_ref_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> $stable(ref_div_o) && $stable(ref_bad_o));

    assert_ndiv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> $stable(a_cnt_o) && $stable(b_cnt_o));

    assert_func_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> $stable(func_word_o));

    assert_bad_means_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_bad_o |-> (ref_div_o == '0));

endmodule

bind synth_prog_port spp_checker i_spp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .le_rise     (le_rise),
    .ref_div_o   (ref_div_o),
    .ref_bad_o   (ref_bad_o),
    .a_cnt_o     (a_cnt_o),
    .b_cnt_o     (b_cnt_o),
    .func_word_o (func_word_o),
    .init_pulse_o(init_pulse_o)
);

// File: tb/test_synth_prog_port.sv
module test_synth_prog_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic        sle_i = 1'b0;
    logic [13:0] ref_div_o;
    logic        ref_bad_o;
    logic [1:0]  abw_o;
    logic [1:0]  test_bits_o;
    logic        lock_prec_o;
    logic [5:0]  a_cnt_o;
    logic [12:0] b_cnt_o;
    logic [21:0] func_word_o;
    logic        init_pulse_o;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    bit done = 1'b0;

    logic [13:0] e_ref;
    logic        e_bad;
    logic [1:0]  e_abw;
    logic [1:0]  e_test;
    logic        e_prec;
    logic [5:0]  e_a;
    logic [12:0] e_b;
    logic [21:0] e_func;
    int          e_pulses;

    always #2 clk = ~clk;

    synth_prog_port i_synth_prog_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk_i),
        .sdata_i     (sdata_i),
        .sle_i       (sle_i),
        .ref_div_o   (ref_div_o),
        .ref_bad_o   (ref_bad_o),
        .abw_o       (abw_o),
        .test_bits_o (test_bits_o),
        .lock_prec_o (lock_prec_o),
        .a_cnt_o     (a_cnt_o),
        .b_cnt_o     (b_cnt_o),
        .func_word_o (func_word_o),
        .init_pulse_o(init_pulse_o)
    );

    always @(negedge clk) if (init_pulse_o) pulses++;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " R3 ref_div"},   32'(ref_div_o),   32'(e_ref));
        check({tag, " R8 ref_bad"},   32'(ref_bad_o),   32'(e_bad));
        check({tag, " R3 abw"},       32'(abw_o),       32'(e_abw));
        check({tag, " R3 test"},      32'(test_bits_o), 32'(e_test));
        check({tag, " R3 prec"},      32'(lock_prec_o), 32'(e_prec));
        check({tag, " R4 a_cnt"},     32'(a_cnt_o),     32'(e_a));
        check({tag, " R4 b_cnt"},     32'(b_cnt_o),     32'(e_b));
        check({tag, " R5 func_word"}, 32'(func_word_o), 32'(e_func));
        check({tag, " R6 init pulses"}, 32'(pulses),    32'(e_pulses));
    endtask

    // model of a load; R7: untouched fields keep their old values
    task automatic model_load(input logic [23:0] w);
        e_pulses = 0;
        case (w[1:0])
            2'b00: begin
                e_ref = w[15:2]; e_bad = (w[15:2] == 14'd0);
                e_abw = w[17:16]; e_test = w[19:18]; e_prec = w[20];
            end
            2'b01: begin e_a = w[7:2]; e_b = w[20:8]; end
            2'b10: e_func = w[23:2];
            default: begin e_func = w[23:2]; e_pulses = 1; end
        endcase
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); sdata_i = v[i];
            repeat (4) @(negedge clk);
            sclk_i = 1'b1;
            repeat (4) @(negedge clk);
            sclk_i = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic strobe();
        pulses = 0;
        @(negedge clk); sle_i = 1'b1;
        repeat (4) @(negedge clk);
        sle_i = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic send_word(input logic [23:0] w, input string tag);
        shift_bits({8'd0, w}, 24);
        strobe();
        model_load(w);
        check_all(tag);
    endtask

    initial begin
        void'($urandom(32'd1234));
        e_ref = '0; e_bad = 0; e_abw = '0; e_test = '0; e_prec = 0;
        e_a = '0; e_b = '0; e_func = '0; e_pulses = 0;
        repeat (5) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1 after release");

        // R3 reference fields at known positions
        send_word({3'b000, 1'b1, 2'b00, 2'b10, 14'h2ABC, 2'b00}, "R3 ref directed");
        // R8 divide value zero flagged, then cleared
        send_word({3'b000, 1'b0, 2'b01, 2'b01, 14'h0000, 2'b00}, "R8 ref zero");
        send_word({3'b000, 1'b0, 2'b00, 2'b00, 14'h0001, 2'b00}, "R8 ref one");
        send_word({3'b000, 1'b1, 2'b11, 2'b11, 14'h3FFF, 2'b00}, "R3 ref max");
        // R4 N counter
        send_word({3'b000, 13'h1FFF, 6'h2A, 2'b01}, "R4 ndiv");
        // R5 / R6 function and init
        send_word(24'hA5A5A6, "R5 func");
        send_word(24'h5A5A5B, "R6 init");
        // R2 extra leading bits fall out of the window
        shift_bits(32'hF, 4);
        send_word({3'b000, 13'h0123, 6'h15, 2'b01}, "R2 overlong");
        // R9 shifting without a strobe changes nothing
        pulses = 0;
        shift_bits({8'd0, 24'hFFFFFE}, 24);
        e_pulses = 0;
        check_all("R9 no strobe");
        // R7 randomized mix over all addresses
        for (int k = 0; k < 40; k++) begin
            send_word(24'($urandom), "R7 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule